// File: doc/BRIEF.md
# Protected-Mode Segment Load Checker

This block handles a write of a selector into one of six segment registers. It checks the selector and keeps, for each register, a cached entry that holds a lower bound, an upper bound, an attribute and a 32-bit default-size flag. Later address checks read those cached entries.

In real mode the bounds come straight from the selector. In protected mode the block has three outcomes:
- A reload of the selector that is already cached as valid finishes without a table access.
- A request that breaks a selector rule is answered with a fault at once.
- Any other request fetches an 8-byte descriptor from the local table over a request/acknowledge read port. The block then validates the descriptor and either reports a fault class or writes new bounds.

A request is issued with a one-cycle `start` while `busy` is low. The result appears with a one-cycle `done`. Faults are reported together with an error code. Any register's cached entry can be read at any time through a query port.

Top module: `seg_load_checker`

## Requirements
- R1: With `prot_mode` low, a load sets the entry's lower bound to `sel`*16 + `mem_base` and its upper bound to the lower bound + 0xFFFF. It sets the attribute to real (encoding 2) and reports fault none. `done` is high in the cycle after `start`. Attribute encodings are: 0 invalid, 1 protected valid, 2 real.
- R2: In protected mode, a load of the selector already held by a register whose attribute is 1 makes no table fetch. It reports fault none, with `big` equal to the cached flag, and `done` is high in the cycle after `start`.
- R3: A selector below 4 loaded into the code register (`sreg`=0) or the stack register (`sreg`=1) gives general-protection fault. Fault codes are: 0 none, 1 general protection, 2 not present, 3 stack. Into a data register (`sreg` 2 to 5) the same selector gives fault none, sets the lower bound to 0xC0000000 and sets the attribute to 0.
- R4: A non-null selector whose bit 2 is clear (global table) gives fault 1 without a fetch.
- R5: A selector whose value with the low three bits cleared exceeds `ldt_limit` gives fault 1 without a fetch.
- R6: A fetched descriptor whose present bit (bit 47) is clear gives fault 3 when the target is the stack register, and fault 2 for every other register.
- R7: A fetched system descriptor (bit 44 clear) of type 0, 8, 10 or 13 (bits 43:40) gives fault 1. Any other system type gives fault none, an upper bound of 0 and attribute 0.
- R8: A code descriptor (type bit 3 set) that is not readable (type bit 1 clear) gives fault 1 when loaded into a data register. A data descriptor loaded into the code register succeeds and pulses `warn_cs_data` together with `done`.
- R9: `err_code` is `sel` with bits 1:0 cleared from the cycle after `start` until completion. It stays at that value after a fault and becomes 0 on fault none.
- R10: A valid code or data load sets the lower bound to the descriptor base + `mem_base`. Base bits 23:0 are at 39:16 and bits 31:24 are at 63:56. The upper bound is the lower bound + the byte limit. The 20-bit limit is at 15:0 and 51:48; when bit 55 is set the byte limit is the limit × 4096 + 0xFFF. The load also sets attribute 1 and sets `big` and the cached flag from bit 54, and pulses `acc_mark` with `done`.
- R11: While fetching, `busy` and `rd_req` are high and `rd_addr` is `sel` with bits 2:0 cleared, until `rd_ack`. `done` follows in the cycle after the acknowledge, and `busy` is never high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 1 selects protected-mode checks |
| mem_base | input | 32 | Offset added to every computed lower bound |
| ldt_limit | input | 16 | Byte limit of the local descriptor table |
| start | input | 1 | One-cycle load request, taken while busy is low |
| sreg | input | 3 | Target register: 0 code, 1 stack, 2 to 5 data |
| sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | Fault class of the last completed load |
| err_code | output | 16 | Error code (selector with RPL cleared, 0 on success) |
| big | output | 1 | 32-bit default-size flag of the last completed load |
| warn_cs_data | output | 1 | Data segment loaded into the code register |
| acc_mark | output | 1 | Request to set the accessed bit of the fetched descriptor at rd_addr |
| rd_req | output | 1 | Descriptor read request |
| rd_addr | output | 16 | Byte offset of the descriptor in the local table |
| rd_ack | input | 1 | Read acknowledge, one cycle, with rd_data valid |
| rd_data | input | 64 | Descriptor returned by the table |
| q_sreg | input | 3 | Register whose cached entry is shown |
| q_lo | output | 32 | Cached lower bound |
| q_hi | output | 32 | Cached upper bound |
| q_attr | output | 2 | Cached attribute |
| q_big | output | 1 | Cached 32-bit flag |

## Verification
The assertions assume the following about the inputs:
- `sreg` is always below 6 when `start` is high.
- `start` is only raised while `busy` is low.
- `rd_ack` is a single-cycle pulse that comes only while `rd_req` is high.

The bench keeps within these rules by issuing each load through one task that waits for `done` before returning. Its table responder answers only an open request, after a fixed latency, and drops the acknowledge on the next cycle. Selectors are picked so that every table index stays inside the modelled table.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned ADDR_W = 32;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2,
    FLT_SS   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ATTR_INV  = 2'd0,
    ATTR_PROT = 2'd1,
    ATTR_REAL = 2'd2
  } attr_e;

  localparam logic [ADDR_W-1:0] NULL_TRAP_LO = 32'hC000_0000;
  localparam logic [ADDR_W-1:0] REAL_SPAN    = 32'h0000_FFFF;
  localparam logic [SEL_W-1:0]  IDX_MASK     = 16'hFFF8;
  localparam logic [SEL_W-1:0]  RPL_CLR_MASK = 16'hFFFC;

  // real-mode lower bound: paragraph number shifted plus memory offset
  function automatic logic [ADDR_W-1:0] real_lo(input logic [SEL_W-1:0] s,
                                                input logic [ADDR_W-1:0] mb);
    return {{(ADDR_W-SEL_W-4){1'b0}}, s, 4'b0000} + mb;
  endfunction

  // byte extent from the 20-bit limit and granularity
  function automatic logic [ADDR_W-1:0] byte_limit(input logic [19:0] lim,
                                                   input logic g);
    return g ? {lim, 12'hFFF} : {12'h000, lim};
  endfunction

  // system types that allow no transfer
  function automatic logic sys_blocked(input logic [3:0] t);
    return (t == 4'd0) || (t == 4'd8) || (t == 4'd10) || (t == 4'd13);
  endfunction
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
  import seg_load_pkg::*;
(
  input  logic [63:0]       raw,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] blim,
  output logic [3:0]        typ,
  output logic              is_user,
  output logic              present,
  output logic              def32
);
  logic [19:0] lim20;
  logic        gran;
  logic        unused_fields;

  assign base    = {raw[63:56], raw[39:16]};
  assign lim20   = {raw[51:48], raw[15:0]};
  assign typ     = raw[43:40];
  assign is_user = raw[44];
  assign present = raw[47];
  assign def32   = raw[54];
  assign gran    = raw[55];
  assign blim    = byte_limit(lim20, gran);
  assign unused_fields = ^{raw[46:45], raw[53:52]};
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_load_pkg::*;
#(
  parameter int unsigned NUM_SREG = 6,
  parameter int unsigned IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [SEL_W-1:0]  wsel,
  input  attr_e             wattr,
  input  logic              wbig,
  input  logic [ADDR_W-1:0] wlo,
  input  logic              wlo_en,
  input  logic [ADDR_W-1:0] whi,
  input  logic              whi_en,
  input  logic [IDX_W-1:0]  lidx,
  output logic [SEL_W-1:0]  lsel,
  output attr_e             lattr,
  output logic              lbig,
  input  logic [IDX_W-1:0]  qidx,
  output logic [ADDR_W-1:0] qlo,
  output logic [ADDR_W-1:0] qhi,
  output attr_e             qattr,
  output logic              qbig
);
  logic [SEL_W-1:0]  e_sel  [NUM_SREG];
  attr_e             e_attr [NUM_SREG];
  logic              e_big  [NUM_SREG];
  logic [ADDR_W-1:0] e_lo   [NUM_SREG];
  logic [ADDR_W-1:0] e_hi   [NUM_SREG];

  for (genvar i = 0; i < NUM_SREG; i++) begin : g_entry
    logic hit_w;
    assign hit_w = we && (widx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_sel[i]  <= '0;
        e_attr[i] <= ATTR_INV;
        e_big[i]  <= 1'b0;
        e_lo[i]   <= '0;
        e_hi[i]   <= '0;
      end else if (hit_w) begin
        e_sel[i]  <= wsel;
        e_attr[i] <= wattr;
        e_big[i]  <= wbig;
        if (wlo_en) e_lo[i] <= wlo;
        if (whi_en) e_hi[i] <= whi;
      end
    end
  end

  always_comb begin
    lsel = '0; lattr = ATTR_INV; lbig = 1'b0;
    qlo = '0; qhi = '0; qattr = ATTR_INV; qbig = 1'b0;
    for (int i = 0; i < NUM_SREG; i++) begin
      if (lidx == IDX_W'(i)) begin
        lsel = e_sel[i]; lattr = e_attr[i]; lbig = e_big[i];
      end
      if (qidx == IDX_W'(i)) begin
        qlo = e_lo[i]; qhi = e_hi[i]; qattr = e_attr[i]; qbig = e_big[i];
      end
    end
  end

  // a write addresses an existing entry (R1, R10)
  a_r10_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx < IDX_W'(NUM_SREG)));
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_load_pkg::*;
#(
  parameter int unsigned NUM_SREG  = 6,
  parameter int unsigned IDX_W     = 3,
  parameter bit          ALLOW_SYS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_mode,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [SEL_W-1:0]  ldt_limit,
  input  logic              start,
  input  logic [IDX_W-1:0]  sreg,
  input  logic [SEL_W-1:0]  sel,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault,
  output logic [SEL_W-1:0]  err_code,
  output logic              big,
  output logic              warn_cs_data,
  output logic              acc_mark,
  output logic              rd_req,
  output logic [SEL_W-1:0]  rd_addr,
  input  logic              rd_ack,
  input  logic [63:0]       rd_data,
  input  logic [IDX_W-1:0]  q_sreg,
  output logic [ADDR_W-1:0] q_lo,
  output logic [ADDR_W-1:0] q_hi,
  output logic [1:0]        q_attr,
  output logic              q_big
);
  localparam logic [IDX_W-1:0] IX_CODE  = '0;
  localparam logic [IDX_W-1:0] IX_STACK = IDX_W'(1);

  typedef enum logic {ST_IDLE, ST_FETCH} st_e;
  st_e st;

  logic [SEL_W-1:0] req_sel, addr_q, err_q;
  logic [IDX_W-1:0] req_sreg;
  fault_e           fault_q;
  logic             done_q, big_q, warn_q, acc_q;

  // cache ports
  logic              c_we, c_big, c_lo_en, c_hi_en;
  logic [IDX_W-1:0]  c_idx;
  logic [SEL_W-1:0]  c_sel;
  attr_e             c_attr, lk_attr, qa;
  logic [ADDR_W-1:0] c_lo, c_hi;
  logic [SEL_W-1:0]  lk_sel;
  logic              lk_big;

  // decoded descriptor
  logic [ADDR_W-1:0] dsc_base, dsc_blim;
  logic [3:0]        dsc_type;
  logic              dsc_user, dsc_p, dsc_db;

  // named events
  logic   accept, fin, hit, sel_null, to_ctrl, sel_global, sel_beyond;
  logic   sys_early_reject, go_fetch;
  logic   r_done, r_big, r_warn, r_acc;
  fault_e r_fault;

  seg_desc_decode u_dec (
    .raw(rd_data), .base(dsc_base), .blim(dsc_blim), .typ(dsc_type),
    .is_user(dsc_user), .present(dsc_p), .def32(dsc_db)
  );

  seg_cache #(.NUM_SREG(NUM_SREG), .IDX_W(IDX_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .we(c_we), .widx(c_idx), .wsel(c_sel), .wattr(c_attr), .wbig(c_big),
    .wlo(c_lo), .wlo_en(c_lo_en), .whi(c_hi), .whi_en(c_hi_en),
    .lidx(sreg), .lsel(lk_sel), .lattr(lk_attr), .lbig(lk_big),
    .qidx(q_sreg), .qlo(q_lo), .qhi(q_hi), .qattr(qa), .qbig(q_big)
  );
  assign q_attr = qa;

  if (ALLOW_SYS) begin : g_sys_table
    assign sys_early_reject = 1'b0;
  end else begin : g_sys_strict
    assign sys_early_reject = !dsc_user;
  end

  assign accept     = start && (st == ST_IDLE);
  assign fin        = (st == ST_FETCH) && rd_ack;
  assign hit        = prot_mode && (lk_attr == ATTR_PROT) && (lk_sel == sel);
  assign sel_null   = (sel < SEL_W'(4));
  assign to_ctrl    = (sreg == IX_CODE) || (sreg == IX_STACK);
  assign sel_global = !sel[2];
  assign sel_beyond = (sel & IDX_MASK) > ldt_limit;

  always_comb begin
    c_we = 1'b0; c_idx = sreg; c_sel = sel; c_attr = ATTR_INV; c_big = 1'b0;
    c_lo = '0; c_lo_en = 1'b0; c_hi = '0; c_hi_en = 1'b0;
    r_done = 1'b0; r_fault = FLT_NONE; r_big = 1'b0; r_warn = 1'b0;
    r_acc = 1'b0; go_fetch = 1'b0;
    if (accept) begin
      if (!prot_mode) begin
        c_we = 1'b1; c_attr = ATTR_REAL;
        c_lo = real_lo(sel, mem_base); c_lo_en = 1'b1;
        c_hi = c_lo + REAL_SPAN;       c_hi_en = 1'b1;
        r_done = 1'b1;
      end else if (hit) begin
        r_done = 1'b1; r_big = lk_big;
      end else if (sel_null) begin
        c_we = 1'b1; r_done = 1'b1;
        if (to_ctrl) r_fault = FLT_GP;
        else begin
          c_lo = NULL_TRAP_LO; c_lo_en = 1'b1;
        end
      end else if (sel_global || sel_beyond) begin
        c_we = 1'b1; r_done = 1'b1; r_fault = FLT_GP;
      end else begin
        go_fetch = 1'b1;
      end
    end else if (fin) begin
      c_we = 1'b1; c_idx = req_sreg; c_sel = req_sel; r_done = 1'b1;
      if (sys_early_reject) begin
        r_fault = FLT_GP;
      end else if (!dsc_p) begin
        r_fault = (req_sreg == IX_STACK) ? FLT_SS : FLT_NP;
      end else if (!dsc_user) begin
        if (sys_blocked(dsc_type)) r_fault = FLT_GP;
        else begin
          c_hi = '0; c_hi_en = 1'b1;
        end
      end else if ((req_sreg != IX_CODE) && dsc_type[3] && !dsc_type[1]) begin
        r_fault = FLT_GP;
      end else begin
        c_attr = ATTR_PROT; c_big = dsc_db; r_big = dsc_db;
        c_lo = dsc_base + mem_base; c_lo_en = 1'b1;
        c_hi = c_lo + dsc_blim;     c_hi_en = 1'b1;
        r_acc  = 1'b1;
        r_warn = (req_sreg == IX_CODE) && !dsc_type[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; req_sel <= '0; req_sreg <= '0; addr_q <= '0; err_q <= '0;
      fault_q <= FLT_NONE; done_q <= 1'b0; big_q <= 1'b0; warn_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      done_q <= r_done;
      acc_q  <= r_acc;
      warn_q <= r_warn;
      if (r_done) begin
        fault_q <= r_fault;
        big_q   <= r_big;
      end
      if (accept) begin
        req_sel  <= sel;
        req_sreg <= sreg;
        addr_q   <= sel & IDX_MASK;
        err_q    <= sel & RPL_CLR_MASK;
      end
      if (r_done && (r_fault == FLT_NONE)) err_q <= '0;
      if (go_fetch) st <= ST_FETCH;
      else if (fin) st <= ST_IDLE;
    end
  end

  assign busy         = (st == ST_FETCH);
  assign rd_req       = (st == ST_FETCH);
  assign rd_addr      = addr_q;
  assign done         = done_q;
  assign fault        = fault_q;
  assign err_code     = err_q;
  assign big          = big_q;
  assign warn_cs_data = warn_q;
  assign acc_mark     = acc_q;

  // input rule: only existing registers are targeted
  a_r1_sreg_valid: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (sreg < IDX_W'(NUM_SREG)));

  a_r1_real_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !prot_mode) |=> (done && fault == FLT_NONE && !busy));

  a_r2_cached_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (done && !busy && fault == FLT_NONE && err_code == '0));

  a_r3_null_ctrl_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prot_mode && !hit && sel_null && to_ctrl) |=> (done && fault == FLT_GP));

  a_r4_global_gp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prot_mode && !hit && !sel_null && !sel[2]) |=>
      (done && !busy && fault == FLT_GP));

  a_r6_absent_class: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !dsc_p && !sys_early_reject) |=>
      (done && fault == (($past(req_sreg) == IX_STACK) ? FLT_SS : FLT_NP)));

  a_r9_success_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == FLT_NONE) |-> (err_code == '0));

  a_r10_acc_on_success: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mark |-> (done && fault == FLT_NONE));

  a_r11_fetch_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && prot_mode && !hit && !sel_null && sel[2] && !sel_beyond) |=>
      (busy && rd_req && !done && rd_addr == ($past(sel) & IDX_MASK)));

  a_r11_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: tb/seg_load_checker_tb_top.sv
module seg_load_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic [31:0] mem_base = '0;
  logic [15:0] ldt_limit = '0;
  logic        start = 1'b0;
  logic [2:0]  sreg = '0;
  logic [15:0] sel = '0;
  logic        busy, done, big, warn_cs_data, acc_mark, rd_req;
  logic [1:0]  fault, q_attr;
  logic [15:0] err_code, rd_addr;
  logic        rd_ack = 1'b0;
  logic [63:0] rd_data = '0;
  logic [2:0]  q_sreg = '0;
  logic [31:0] q_lo, q_hi;
  logic        q_big;

  int checks = 0, errors = 0, fetches = 0, cycles = 0;
  logic [63:0] table_m [16];

  // captured per load
  logic [1:0]  o_fault;
  logic [15:0] o_err, o_err_busy, o_addr;
  logic        o_big, o_warn, o_acc, o_busy, o_req;
  int          o_wait;

  always #4 clk = ~clk;

  seg_load_checker dut_i (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode), .mem_base(mem_base),
    .ldt_limit(ldt_limit), .start(start), .sreg(sreg), .sel(sel),
    .busy(busy), .done(done), .fault(fault), .err_code(err_code), .big(big),
    .warn_cs_data(warn_cs_data), .acc_mark(acc_mark), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .q_sreg(q_sreg),
    .q_lo(q_lo), .q_hi(q_hi), .q_attr(q_attr), .q_big(q_big)
  );

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
      input logic [3:0] t, input logic usr, input logic p, input logic d, input logic g);
    logic [63:0] v;
    v = 64'(l[15:0]) | (64'(l[19:16]) << 48);
    v = v | (64'(b[23:0]) << 16) | (64'(b[31:24]) << 56);
    v = v | (64'(t) << 40) | (64'(usr) << 44) | (64'(p) << 47);
    v = v | (64'(d) << 54) | (64'(g) << 55);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // table responder: fixed latency of three cycles
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        if (lat == 2) begin
          rd_ack = 1'b1; rd_data = table_m[rd_addr[6:3]]; lat = 0; fetches++;
        end else lat++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic do_load(input logic [2:0] r, input logic [15:0] s);
    @(negedge clk);
    sreg = r; sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    o_busy = busy; o_req = rd_req; o_addr = rd_addr; o_err_busy = err_code;
    o_wait = 0;
    while (!done && o_wait < 50) begin
      @(negedge clk);
      o_wait++;
    end
    o_fault = fault; o_err = err_code; o_big = big; o_warn = warn_cs_data; o_acc = acc_mark;
  endtask

  task automatic peek(input logic [2:0] r);
    q_sreg = r;
    #1;
  endtask

  task automatic t_reset;
    check("R11 reset busy", 32'(busy), 0);
    check("R11 reset done", 32'(done), 0);
    for (int i = 0; i < 6; i++) begin
      peek(3'(i));
      check("R1 reset attr", 32'(q_attr), 0);
    end
  endtask

  task automatic t_real;
    prot_mode = 1'b0; mem_base = 32'h0001_0000;
    do_load(3'd2, 16'h1234);
    check("R1 real wait", 32'(o_wait), 0);
    check("R1 real fault", 32'(o_fault), 0);
    peek(3'd2);
    check("R1 real lo", q_lo, 32'h0002_2340);
    check("R1 real hi", q_hi, 32'h0003_233F);
    check("R1 real attr", 32'(q_attr), 2);
  endtask

  task automatic t_fetch_ok;
    prot_mode = 1'b1; mem_base = 32'h0100_0000;
    do_load(3'd2, 16'h000F);
    check("R11 busy while fetching", 32'(o_busy), 1);
    check("R11 rd_req while fetching", 32'(o_req), 1);
    check("R11 rd_addr", 32'(o_addr), 32'h0008);
    check("R11 done after ack", 32'(o_wait), 3);
    check("R9 err while busy", 32'(o_err_busy), 32'h000C);
    check("R10 fault", 32'(o_fault), 0);
    check("R9 err cleared", 32'(o_err), 0);
    check("R10 big", 32'(o_big), 1);
    check("R10 acc_mark", 32'(o_acc), 1);
    check("R8 no warn for data reg", 32'(o_warn), 0);
    peek(3'd2);
    check("R10 lo", q_lo, 32'h0110_0000);
    check("R10 hi", q_hi, 32'h0110_0FFF);
    check("R10 attr", 32'(q_attr), 1);
    check("R10 cached flag", 32'(q_big), 1);
  endtask

  task automatic t_granular;
    do_load(3'd3, 16'h0014);
    check("R10 gran fault", 32'(o_fault), 0);
    check("R10 gran big", 32'(o_big), 0);
    peek(3'd3);
    check("R10 gran lo", q_lo, 32'h0120_0000);
    check("R10 gran hi", q_hi, 32'h0120_3FFF);
  endtask

  task automatic t_cached;
    int f0;
    f0 = fetches;
    do_load(3'd2, 16'h000F);
    check("R2 no fetch", 32'(fetches - f0), 0);
    check("R2 one cycle", 32'(o_wait), 0);
    check("R2 busy low", 32'(o_busy), 0);
    check("R2 fault", 32'(o_fault), 0);
    check("R2 big", 32'(o_big), 1);
  endtask

  task automatic t_null;
    do_load(3'd0, 16'h0002);
    check("R3 null code gp", 32'(o_fault), 1);
    check("R3 null code err", 32'(o_err), 0);
    do_load(3'd1, 16'h0000);
    check("R3 null stack gp", 32'(o_fault), 1);
    do_load(3'd2, 16'h0003);
    check("R3 null data ok", 32'(o_fault), 0);
    peek(3'd2);
    check("R3 null data lo", q_lo, 32'hC000_0000);
    check("R3 null data attr", 32'(q_attr), 0);
  endtask

  task automatic t_global;
    int f0;
    f0 = fetches;
    do_load(3'd4, 16'h0008);
    check("R4 global gp", 32'(o_fault), 1);
    check("R4 global err", 32'(o_err), 32'h0008);
    check("R4 no fetch", 32'(fetches - f0), 0);
  endtask

  task automatic t_limit;
    int f0;
    f0 = fetches;
    do_load(3'd5, 16'h0087);
    check("R5 beyond gp", 32'(o_fault), 1);
    check("R5 beyond err", 32'(o_err), 32'h0084);
    check("R5 no fetch", 32'(fetches - f0), 0);
    do_load(3'd5, 16'h007C);
    check("R5 last entry ok", 32'(o_fault), 0);
  endtask

  task automatic t_absent;
    do_load(3'd1, 16'h001C);
    check("R6 stack absent", 32'(o_fault), 3);
    check("R9 err kept on fault", 32'(o_err), 32'h001C);
    do_load(3'd5, 16'h001C);
    check("R6 data absent", 32'(o_fault), 2);
    peek(3'd5);
    check("R6 attr invalid", 32'(q_attr), 0);
  endtask

  task automatic t_system;
    do_load(3'd4, 16'h0024);
    check("R7 sys accepted", 32'(o_fault), 0);
    peek(3'd4);
    check("R7 sys hi zero", q_hi, 0);
    check("R7 sys attr", 32'(q_attr), 0);
    do_load(3'd4, 16'h002C);
    check("R7 sys type 8 gp", 32'(o_fault), 1);
    do_load(3'd4, 16'h0044);
    check("R7 sys type 13 gp", 32'(o_fault), 1);
  endtask

  task automatic t_code_data;
    do_load(3'd3, 16'h0034);
    check("R8 exec-only in data gp", 32'(o_fault), 1);
    do_load(3'd0, 16'h0034);
    check("R8 exec-only in code ok", 32'(o_fault), 0);
    check("R8 code in code no warn", 32'(o_warn), 0);
    do_load(3'd0, 16'h000C);
    check("R8 data in code ok", 32'(o_fault), 0);
    check("R8 data in code warn", 32'(o_warn), 1);
    do_load(3'd3, 16'h003C);
    check("R8 readable code in data ok", 32'(o_fault), 0);
    check("R8 no warn", 32'(o_warn), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) table_m[i] = '0;
    table_m[1] = mk_desc(32'h0010_0000, 20'h00FFF, 4'h2, 1, 1, 1, 0);
    table_m[2] = mk_desc(32'h0020_0000, 20'h00003, 4'h2, 1, 1, 0, 1);
    table_m[3] = mk_desc(32'h0030_0000, 20'h0FFFF, 4'h2, 1, 0, 0, 0);
    table_m[4] = mk_desc(32'h0040_0000, 20'h000FF, 4'h2, 0, 1, 0, 0);
    table_m[5] = mk_desc(32'h0050_0000, 20'h000FF, 4'h8, 0, 1, 0, 0);
    table_m[6] = mk_desc(32'h0060_0000, 20'h00FFF, 4'h8, 1, 1, 1, 0);
    table_m[7] = mk_desc(32'h0070_0000, 20'h00FFF, 4'hA, 1, 1, 1, 0);
    table_m[8] = mk_desc(32'h0080_0000, 20'h000FF, 4'hD, 0, 1, 0, 0);
    table_m[15] = mk_desc(32'h00F0_0000, 20'h000FF, 4'h2, 1, 1, 0, 0);
    ldt_limit = 16'h007F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_fetch_ok();
    t_granular();
    t_cached();
    t_null();
    t_global();
    t_limit();
    t_absent();
    t_system();
    t_code_data();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule